// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block drives an external chain of serial-in/parallel-out shift registers through two wires, a shift clock and a data line. It sends out a 17-bit pattern. Software can write that pattern directly. In refresh mode, the pattern follows a vector of PWM channel outputs, so external LEDs track the internal waveform generators without software involvement.

Each transfer sends the pattern most-significant bit first. The receiver samples each bit on a rising shift clock. A programmable divider sets the bit period, and a bounded delay sets how long after each falling clock edge the data line moves to the next bit. While a transfer runs, bit 31 of the status word reads 1. During that time, writes to the pattern and to the mode register are dropped. If no-latch mode is clear, a one-cycle latch strobe follows each transfer, for chains that need a storage clock.

Top module: `serial_led_shifter`

## Requirements
- R1: After reset, the status word, the mode readback, the shift clock, the data line and the latch strobe are all 0.
- R2: A pattern write while idle stores bits 16:0 and starts a transfer of that pattern. Status bit 31 reads 1 from the next cycle for exactly 17 x P cycles, where P is the bit period.
- R3: Each transfer makes exactly 17 rising shift-clock edges. The data line carries the pattern most-significant bit first, valid at each rising edge.
- R4: Divider select s (2 bits) gives P = 4 << s internal clocks, i.e. 0 -> 4, 1 -> 8, 2 -> 16, 3 -> 32. Each shift-clock high pulse lasts P/2 cycles.
- R5: With delay setting d, the data line changes only at bit boundaries, d+1 cycles after a falling shift clock. The rising edge comes P/2-1-d cycles after each boundary. A setting above P/2-1 acts as P/2-1.
- R6: A pattern write while busy is dropped. The stored pattern and the transfer in progress are unchanged.
- R7: A mode write while busy is dropped.
- R8: While idle, the shift clock and the data line are low.
- R9: Mode bit 0 is no-latch. When it is clear, the latch strobe is high for exactly the one cycle in which busy first reads 0. When it is set, no strobe occurs.
- R10: Mode bit 1 enables refresh. The channel vector is registered once. When that registered copy differs from the stored pattern and the block is idle, a transfer of it starts, and it becomes the stored pattern. Busy reads 1 two cycles after the vector changes. An all-zero vector against an all-zero stored pattern starts nothing.
- R11: With mode bit 1 clear, changes of the channel vector start no transfer and leave the stored pattern unchanged.
- R12: If a pattern write and a refresh trigger fall in the same idle cycle, the write wins. The refresh of the differing vector starts the cycle after that transfer ends.
- R13: The divider and delay settings can be written at any time. They are captured when a transfer starts, so a change during a transfer applies only to the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| data_we | input | 1 | Pattern write strobe |
| data_wdata | input | 17 | Pattern to write |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode: bit 1 refresh enable, bit 0 no-latch |
| cfg_we | input | 1 | Timing configuration write strobe |
| cfg_div | input | 2 | Divider select |
| cfg_dly | input | 4 | Clock-to-data delay setting |
| pwm_vec | input | 17 | PWM channel output vector |
| status_word | output | 32 | Bit 31 busy, bits 16:0 stored pattern |
| mode_rd | output | 2 | Mode readback |
| sr_clk | output | 1 | Shift clock to the chain |
| sr_data | output | 1 | Serial data to the chain |
| sr_latch | output | 1 | Storage strobe after a transfer |

## Verification
A software pattern write and a refresh trigger from a changed channel vector can land on the same idle clock edge. The bench provokes this by changing the channel vector, then asserting a pattern write one cycle later, so that both reach the edge that follows. It judges the outcome at the pins. The first transfer must carry the written pattern. A second transfer, carrying the channel vector, must begin in the sample right after the first transfer ends. A pattern or mode write inside a running transfer is the other collision. The bench injects such writes mid-transfer and checks both the serial stream and the readback afterwards.

// File: rtl/sls_pkg.sv
package sls_pkg;
  localparam int unsigned DIV_SEL_W  = 2;
  localparam int unsigned MIN_PERIOD = 4;
  localparam int unsigned MAX_PERIOD = MIN_PERIOD << ((1 << DIV_SEL_W) - 1);

  typedef struct packed {
    logic refresh_en;
    logic no_latch;
  } sls_mode_t;

  function automatic int unsigned period_of(input logic [DIV_SEL_W-1:0] sel);
    return MIN_PERIOD << sel;
  endfunction
endpackage

// File: rtl/sls_regs.sv
module sls_regs
  import sls_pkg::*;
#(
  parameter int NBITS = 17,
  parameter int DLYW  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 data_we,
  input  logic [NBITS-1:0]     data_wdata,
  input  logic                 mode_we,
  input  sls_mode_t            mode_wdata,
  input  logic                 cfg_we,
  input  logic [DIV_SEL_W-1:0] cfg_div,
  input  logic [DLYW-1:0]      cfg_dly,
  input  logic [NBITS-1:0]     pwm_vec,
  input  logic                 busy_i,
  output logic [NBITS-1:0]     data_q,
  output sls_mode_t            mode_q,
  output logic [DIV_SEL_W-1:0] div_q,
  output logic [DLYW-1:0]      dly_q,
  output logic                 start_o,
  output logic [NBITS-1:0]     start_val_o
);
  logic [NBITS-1:0] pwm_q;
  logic             sw_go;
  logic             pwm_go;

  always_comb begin
    sw_go       = data_we && !busy_i;
    pwm_go      = mode_q.refresh_en && !busy_i && !data_we && (pwm_q != data_q);
    start_o     = sw_go || pwm_go;
    start_val_o = sw_go ? data_wdata : pwm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q  <= '0;
      data_q <= '0;
      mode_q <= '0;
      div_q  <= '0;
      dly_q  <= '0;
    end else begin
      pwm_q <= pwm_vec;
      if (start_o) data_q <= start_val_o;
      if (mode_we && !busy_i) mode_q <= mode_wdata;
      if (cfg_we) begin
        div_q <= cfg_div;
        dly_q <= cfg_dly;
      end
    end
  end

  assert_busy_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_i && data_we) |=> $stable(data_q));

  assert_busy_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_i && mode_we) |=> $stable(mode_q));
endmodule

// File: rtl/sls_shifter.sv
module sls_shifter
  import sls_pkg::*;
#(
  parameter int NBITS = 17,
  parameter int DLYW  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [NBITS-1:0]     start_val_i,
  input  logic [DIV_SEL_W-1:0] div_i,
  input  logic [DLYW-1:0]      dly_i,
  input  logic                 no_latch_i,
  output logic                 busy_o,
  output logic                 sclk_o,
  output logic                 sdo_o,
  output logic                 latch_o
);
  localparam int CNTW = $clog2(MAX_PERIOD);
  localparam int BITW = $clog2(NBITS);

  logic             busy_q, sclk_q, sdo_q, latch_q, nolatch_q;
  logic [NBITS-1:0] sh_q;
  logic [CNTW-1:0]  off_q, last_q, rise_q, half_q;
  logic [BITW-1:0]  bit_q;
  logic [CNTW-1:0]  half_c, rise_c, last_c, nxt;

  always_comb begin
    int unsigned per, half, de;
    per    = period_of(div_i);
    half   = per / 2;
    de     = (int'(dly_i) > half - 1) ? half - 1 : int'(dly_i);
    half_c = CNTW'(half);
    rise_c = CNTW'(half - 1 - de);
    last_c = CNTW'(per - 1);
    nxt    = off_q + 1'b1;
  end

  function automatic logic high_at(input logic [CNTW-1:0] o, input logic [CNTW-1:0] r,
                                   input logic [CNTW-1:0] h);
    return (o >= r) && ({1'b0, o} < ({1'b0, r} + {1'b0, h}));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      sclk_q    <= 1'b0;
      sdo_q     <= 1'b0;
      latch_q   <= 1'b0;
      nolatch_q <= 1'b0;
      sh_q      <= '0;
      off_q     <= '0;
      last_q    <= '0;
      rise_q    <= '0;
      half_q    <= '0;
      bit_q     <= '0;
    end else begin
      latch_q <= 1'b0;
      if (start_i) begin
        busy_q    <= 1'b1;
        sh_q      <= start_val_i << 1;
        sdo_q     <= start_val_i[NBITS-1];
        off_q     <= '0;
        bit_q     <= '0;
        half_q    <= half_c;
        rise_q    <= rise_c;
        last_q    <= last_c;
        nolatch_q <= no_latch_i;
        sclk_q    <= (rise_c == '0);
      end else if (busy_q) begin
        if (off_q == last_q) begin
          if (bit_q == BITW'(NBITS - 1)) begin
            busy_q  <= 1'b0;
            sclk_q  <= 1'b0;
            sdo_q   <= 1'b0;
            latch_q <= !nolatch_q;
          end else begin
            off_q  <= '0;
            bit_q  <= bit_q + 1'b1;
            sdo_q  <= sh_q[NBITS-1];
            sh_q   <= sh_q << 1;
            sclk_q <= (rise_q == '0);
          end
        end else begin
          off_q  <= nxt;
          sclk_q <= high_at(nxt, rise_q, half_q);
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign sclk_o  = sclk_q;
  assign sdo_o   = sdo_q;
  assign latch_o = latch_q;

  assert_start_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q);

  assert_idle_lines_low_R8: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!sclk_q && !sdo_q));

  assert_latch_outside_busy_R9: assert property (@(posedge clk) disable iff (rst)
    latch_q |-> !busy_q);

  assert_all_bits_sent_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ($past(bit_q) == BITW'(NBITS - 1)));
endmodule

// File: rtl/serial_led_shifter.sv
module serial_led_shifter
  import sls_pkg::*;
#(
  parameter int NBITS = 17,
  parameter int DLYW  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 data_we,
  input  logic [NBITS-1:0]     data_wdata,
  input  logic                 mode_we,
  input  logic [1:0]           mode_wdata,
  input  logic                 cfg_we,
  input  logic [DIV_SEL_W-1:0] cfg_div,
  input  logic [DLYW-1:0]      cfg_dly,
  input  logic [NBITS-1:0]     pwm_vec,
  output logic [31:0]          status_word,
  output logic [1:0]           mode_rd,
  output logic                 sr_clk,
  output logic                 sr_data,
  output logic                 sr_latch
);
  logic [NBITS-1:0]     data_q, start_val;
  sls_mode_t            mode_q;
  logic [DIV_SEL_W-1:0] div_q;
  logic [DLYW-1:0]      dly_q;
  logic                 start, busy;

  sls_regs #(.NBITS(NBITS), .DLYW(DLYW)) regs_i (
    .clk(clk), .rst(rst),
    .data_we(data_we), .data_wdata(data_wdata),
    .mode_we(mode_we), .mode_wdata(sls_mode_t'(mode_wdata)),
    .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_dly(cfg_dly),
    .pwm_vec(pwm_vec), .busy_i(busy),
    .data_q(data_q), .mode_q(mode_q), .div_q(div_q), .dly_q(dly_q),
    .start_o(start), .start_val_o(start_val)
  );

  sls_shifter #(.NBITS(NBITS), .DLYW(DLYW)) shift_i (
    .clk(clk), .rst(rst),
    .start_i(start), .start_val_i(start_val),
    .div_i(div_q), .dly_i(dly_q), .no_latch_i(mode_q.no_latch),
    .busy_o(busy), .sclk_o(sr_clk), .sdo_o(sr_data), .latch_o(sr_latch)
  );

  assign status_word = {busy, {(31 - NBITS){1'b0}}, data_q};
  assign mode_rd     = mode_q;
endmodule

// File: tb/serial_led_shifter_tb_top.sv
module serial_led_shifter_tb_top;
  localparam int NB = 17;
  localparam int DW = 4;

  logic          clk = 1'b0, rst = 1'b1;
  logic          data_we = 1'b0, mode_we = 1'b0, cfg_we = 1'b0;
  logic [NB-1:0] data_wdata = '0, pwm_vec = '0;
  logic [1:0]    mode_wdata = '0, cfg_div = '0;
  logic [DW-1:0] cfg_dly = '0;
  logic [31:0]   status_word;
  logic [1:0]    mode_rd;
  logic          sr_clk, sr_data, sr_latch;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  serial_led_shifter dut_i (
    .clk(clk), .rst(rst), .data_we(data_we), .data_wdata(data_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .cfg_we(cfg_we),
    .cfg_div(cfg_div), .cfg_dly(cfg_dly), .pwm_vec(pwm_vec),
    .status_word(status_word), .mode_rd(mode_rd),
    .sr_clk(sr_clk), .sr_data(sr_data), .sr_latch(sr_latch)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int eff_dly(input int div, input int dly);
    int half = (4 << div) / 2;
    return (dly > half - 1) ? half - 1 : dly;
  endfunction

  task automatic set_cfg(input int div, input int dly);
    cfg_we = 1; cfg_div = 2'(div); cfg_dly = DW'(dly);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_we = 1; mode_wdata = m;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic sw_write(input logic [NB-1:0] v);
    data_we = 1; data_wdata = v;
    @(negedge clk); data_we = 0;
  endtask

  // Called at the first sample after the start edge (offset 0 of bit 0).
  task automatic run_shift(input logic [NB-1:0] exp, input int div, input int dly,
                           input int no_latch, input int inj, input logic [NB-1:0] injv,
                           input int injdiv);
    int D = 4 << div;
    int de = eff_dly(div, dly);
    int n = 0, first = -1, nrise = 0, hi_run = 0, bad_hi = 0, bad_dl = 0, last_fall = 0;
    logic prev_s = 0, prev_d = 0;
    logic [NB-1:0] word = '0;
    while (status_word[31] === 1'b1 && n < 40 * D * NB) begin
      if (n == inj) begin
        data_we = 1; data_wdata = injv; mode_we = 1; mode_wdata = 2'b11;
        cfg_we = 1; cfg_div = 2'(injdiv); cfg_dly = DW'(dly);
      end
      if (n == inj + 1) begin data_we = 0; mode_we = 0; cfg_we = 0; end
      if (sr_clk && !prev_s) begin
        word = {word[NB-2:0], sr_data}; nrise++;
        if (first < 0) first = n;
      end
      if (!sr_clk && prev_s) begin
        last_fall = n;
        if (hi_run != D / 2) bad_hi++;
      end
      hi_run = sr_clk ? hi_run + 1 : 0;
      if (n > 0 && n % D == 0 && n - last_fall != de + 1) bad_dl++;
      if (n > 0 && sr_data !== prev_d && n % D != 0) bad_dl++;
      prev_s = sr_clk; prev_d = sr_data; n++;
      @(negedge clk);
    end
    data_we = 0; mode_we = 0; cfg_we = 0;
    check("R2 busy cycles", n, NB * D);
    check("R3 serial word", word, exp);
    check("R3 rising edges", nrise, NB);
    check("R4 high pulse width errors", bad_hi, 0);
    check("R5 rise offset", first, D / 2 - 1 - de);
    check("R5 data timing errors", bad_dl, 0);
    check("R8 idle lines", {sr_clk, sr_data}, 2'b00);
    check("R9 latch at end", sr_latch, no_latch ? 0 : 1);
    @(negedge clk);
    check("R9 latch one cycle", sr_latch, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [NB-1:0] a, b, v, w, s;
    int cnt;
    seed = $urandom(32'h5EED);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 status after reset", status_word, 0);
    check("R1 mode after reset", mode_rd, 0);
    check("R1 pins after reset", {sr_clk, sr_data, sr_latch}, 0);

    // Directed: fastest clock, one-hot end bits
    sw_write(17'h10001);
    run_shift(17'h10001, 0, 0, 0, -1, '0, 0);
    check("R2 stored pattern", status_word[NB-1:0], 17'h10001);

    // Slowest clock, max legal delay; then clamp of an oversize delay
    set_cfg(3, 15);
    sw_write(17'h0AAAA);
    run_shift(17'h0AAAA, 3, 15, 0, -1, '0, 0);
    set_cfg(1, 9);
    sw_write(17'h15555);
    run_shift(17'h15555, 1, 9, 0, -1, '0, 0);

    // Random patterns, dividers, delays and latch modes
    for (int i = 0; i < 20; i++) begin
      int dv, dl, nl;
      dv = $urandom % 4; dl = $urandom % 16; nl = $urandom % 2;
      v  = NB'($urandom);
      set_cfg(dv, dl);
      set_mode({1'b0, 1'(nl)});
      sw_write(v);
      run_shift(v, dv, dl, nl, -1, '0, 0);
      check("R2 stored pattern random", status_word[NB-1:0], v);
    end

    // R6/R7/R13: writes during a transfer
    set_cfg(0, 1);
    set_mode(2'b00);
    a = 17'h1F0F0; b = 17'h00F0F;
    sw_write(a);
    run_shift(a, 0, 1, 0, 3, b, 2);
    check("R6 pattern kept", status_word[NB-1:0], a);
    check("R7 mode kept", mode_rd, 2'b00);
    s = 17'h0C3C3;
    sw_write(s);
    run_shift(s, 2, 1, 0, -1, '0, 0); // R13: new divider used only now

    // R10: refresh mode
    set_cfg(1, 2);
    sw_write('0);
    run_shift('0, 1, 2, 0, -1, '0, 0);
    set_mode(2'b10);
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      if (status_word[31]) cnt++;
      @(negedge clk);
    end
    check("R10 zero vector no shift", cnt, 0);
    v = 17'h12345;
    pwm_vec = v;
    @(negedge clk);
    check("R10 not busy after one cycle", status_word[31], 0);
    @(negedge clk);
    check("R10 busy after two cycles", status_word[31], 1);
    run_shift(v, 1, 2, 0, -1, '0, 0);
    check("R10 stored refreshed vector", status_word[NB-1:0], v);

    // R12: write and refresh trigger on the same edge
    w = 17'h0BEEF; s = 17'h1CAFE;
    pwm_vec = w;
    @(negedge clk);
    data_we = 1; data_wdata = s;
    @(negedge clk);
    data_we = 0;
    check("R12 write started", status_word[31], 1);
    run_shift(s, 1, 2, 0, -1, '0, 0);
    check("R12 refresh follows", status_word[31], 1);
    run_shift(w, 1, 2, 0, -1, '0, 0);
    check("R12 final pattern", status_word[NB-1:0], w);

    // R11: refresh disabled
    set_mode(2'b00);
    pwm_vec = 17'h0F00F;
    cnt = 0;
    for (int k = 0; k < 12; k++) begin
      if (status_word[31]) cnt++;
      @(negedge clk);
    end
    check("R11 no shift when refresh off", cnt, 0);
    check("R11 pattern unchanged", status_word[NB-1:0], w);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule